// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block carries one coprocessor instruction through to completion against an external coprocessor. A processor core starts it with a pulse and gives the operation kind, the coprocessor number, a start address, an operand word and a writeback flag. The sequencer then runs a handshake: it presents a phase code and the coprocessor number each cycle, and reads back a response code. The operations are a word sent to the coprocessor, a word read from the coprocessor, an internal coprocessor data operation, a multi-word load from memory into the coprocessor, and a multi-word store from the coprocessor to memory. Load and store addresses go up by 4 after each word.

Before any handshake starts, the block checks a per-coprocessor permission vector and, for loads and stores, the start address. While the coprocessor reports busy, the sequencer idles for one cycle between polls. It gives up if an interrupt is pending in that idle cycle. Each instruction ends with a one-cycle `done` pulse. Next to `done` come flags for an undefined-instruction trap, a coprocessor abort, an abandonment for interrupt and a base-writeback request. A word read from the coprocessor is returned on `rd_data`.

Top module: `cp_hs_seq`

## Requirements
- R1: Phase codes are 0 none, 1 FIRST, 2 BUSY, 3 INTERRUPT, 4 TRANSFER, 5 DATA. Response codes are 0 BUSY, 1 CANT, 2 INC, 3 DONE. Operation codes are 0 to-coprocessor, 1 from-coprocessor, 2 data operation, 3 load, 4 store. Every accepted instruction opens with a FIRST phase. `done` is a one-cycle pulse, and it is low again in the following cycle.
- R2: If bit `cp_sel` of `cp_perm` is 0, `done` and `undef_trap` come one cycle after `start` and no phase is ever presented.
- R3: A BUSY response to FIRST or BUSY is followed by one cycle with no phase. If no interrupt is pending in that cycle, the block then presents a BUSY phase. Each busy response adds two cycles.
- R4: If `irq_pend` is high in the idle cycle of a busy wait, the block presents one INTERRUPT phase, then ends with `done` and `abandoned`. With no busy response, `irq_pend` has no effect.
- R5: A CANT response ends the instruction one cycle later. It raises `undef_trap` for operations 0 to 2 and `cp_abort` for loads and stores.
- R6: A load presents TRANSFER and then DATA. In DATA the block reads memory at the current address and passes the word on `cp_wdata`. On an INC response the address goes up by 4 and another DATA cycle follows. Latency is 3 + words cycles.
- R7: A store presents DATA cycles with no TRANSFER. Each DATA cycle writes `cp_rdata` to memory, and the address goes up by 4 on INC. Latency is 2 + words cycles.
- R8: A load or store with any of address bits 31:26 set, or a store below address 0x20, ends with `cp_abort` one cycle after `start` and presents no phase. A load below 0x20 runs normally.
- R9: `wb_req` is asserted with `done` when a load or store with `wb_bit` set got past the FIRST handshake.
- R10: A from-coprocessor transfer returns the coprocessor word sampled at the accepting response on `rd_data`. If it is refused, `rd_data` is 0xF0000000.
- R11: With an immediate DONE response, `done` comes 2 cycles after `start` for a data operation, 3 for a to-coprocessor transfer and 4 for a from-coprocessor transfer.
- R12: `mem_abort` during a DATA cycle ends the instruction after that word, with `cp_abort`, even if the response was INC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| op | input | 3 | Operation code |
| cp_sel | input | 4 | Coprocessor number |
| wb_bit | input | 1 | Base writeback wanted |
| start_addr | input | 32 | First load/store address |
| src_data | input | 32 | Word for a to-coprocessor transfer |
| cp_perm | input | 16 | Per-coprocessor permission bits |
| irq_pend | input | 1 | Interrupt pending |
| cp_resp | input | 2 | Coprocessor response code |
| cp_rdata | input | 32 | Word from the coprocessor |
| mem_rdata | input | 32 | Memory read data |
| mem_abort | input | 1 | Memory abort for the current word |
| cp_phase | output | 3 | Phase code |
| cp_num | output | 4 | Coprocessor number being driven |
| cp_wdata | output | 32 | Word to the coprocessor |
| mem_addr | output | 32 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| done | output | 1 | Instruction finished |
| undef_trap | output | 1 | Undefined-instruction trap (with done) |
| cp_abort | output | 1 | Coprocessor abort (with done) |
| abandoned | output | 1 | Given up for interrupt (with done) |
| wb_req | output | 1 | Base writeback request (with done) |
| rd_data | output | 32 | Word returned by a from-coprocessor transfer |

## Verification
The bench counts cycles from `start` to `done` for every operation kind, with and without busy waits. An off-by-one in the idle cycle or in the extra cycles of the register transfers shows up as a wrong latency. It drives a pending interrupt with no busy response, where a design that looked at the interrupt too early would abandon a data operation that should finish. It applies a load to the vector area, which a design that checked that area for loads as well as stores would abort. It raises a memory abort in the middle of an INC run, which a design that did not stop after that word would carry on transferring. It also checks the memory contents after a store, the words and addresses passed during a load, and `rd_data` for both an accepted and a refused read from the coprocessor.

// File: rtl/cp_hs_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the coprocessor handshake sequencer.
// Assumes the phase/response code values are fixed by the attached coprocessor.
package cp_hs_pkg;
    typedef enum logic [2:0] {
        PH_NONE = 3'd0, PH_FIRST = 3'd1, PH_BUSY = 3'd2,
        PH_INTR = 3'd3, PH_XFER = 3'd4, PH_DATA = 3'd5
    } phase_t;

    typedef enum logic [1:0] {
        RSP_BUSY = 2'd0, RSP_CANT = 2'd1, RSP_INC = 2'd2, RSP_DONE = 2'd3
    } resp_t;

    typedef enum logic [2:0] {
        OP_TO_CP = 3'd0, OP_FROM_CP = 3'd1, OP_DATAOP = 3'd2,
        OP_LOAD = 3'd3, OP_STORE = 3'd4
    } op_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FIRST, ST_WAIT, ST_POLL, ST_INTR,
        ST_CCYC, ST_ICYC, ST_XFER, ST_DATA, ST_END
    } state_t;
endpackage

// File: rtl/cp_entry_check.sv
`timescale 1ns/1ps
// Entry screening: decides, before any handshake, whether an instruction is
// refused for permission or aborted for its start address.
// Assumes a flat address space of ADDR_W bits and a vector area below VEC_LIMIT.
module cp_entry_check
    import cp_hs_pkg::*;
#(
    parameter int NUM_CP    = 16,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 26,
    parameter int VEC_LIMIT = 32
) (
    input  logic [2:0]                  op,
    input  logic [$clog2(NUM_CP)-1:0]   cp_sel,
    input  logic [NUM_CP-1:0]           cp_perm,
    input  logic [DATA_W-1:0]           addr,
    output logic                        deny,
    output logic                        addr_fault
);
    localparam logic [DATA_W-1:0] VEC_TOP = DATA_W'(VEC_LIMIT);

    logic is_ld, is_st, high_bits, in_vec;

    // Classify the request and test the address against both fault windows.
    always_comb begin
        is_ld      = (op == OP_LOAD);
        is_st      = (op == OP_STORE);
        high_bits  = |addr[DATA_W-1:ADDR_W];
        in_vec     = (addr < VEC_TOP);
        deny       = ~cp_perm[cp_sel];
        addr_fault = (is_ld & high_bits) | (is_st & (high_bits | in_vec));
    end
endmodule

// File: rtl/cp_addr_step.sv
`timescale 1ns/1ps
// Transfer address register: loads the start address and post-increments by
// STEP for each further word. Assumes load and step are never high together.
module cp_addr_step #(
    parameter int DATA_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              step,
    output logic [DATA_W-1:0] addr
);
    // Hold, reload or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (load) addr <= load_val;
        else if (step) addr <= addr + DATA_W'(STEP);
    end
endmodule

// File: rtl/cp_hs_seq.sv
`timescale 1ns/1ps
// Coprocessor handshake sequencer (top). Runs one coprocessor instruction:
// entry screening, FIRST/BUSY polling with idle cycles, interrupt abandonment,
// register transfers, data operations and multi-word load/store.
// Assumes the coprocessor answers combinationally in the cycle of each phase
// and memory reads complete within the DATA cycle.
module cp_hs_seq
    import cp_hs_pkg::*;
#(
    parameter int          NUM_CP    = 16,
    parameter int          DATA_W    = 32,
    parameter int          ADDR_W    = 26,
    parameter int          VEC_LIMIT = 32,
    parameter logic [31:0] FLAG_PAT  = 32'hF000_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [2:0]                op,
    input  logic [$clog2(NUM_CP)-1:0] cp_sel,
    input  logic                      wb_bit,
    input  logic [DATA_W-1:0]         start_addr,
    input  logic [DATA_W-1:0]         src_data,
    input  logic [NUM_CP-1:0]         cp_perm,
    input  logic                      irq_pend,
    input  logic [1:0]                cp_resp,
    input  logic [DATA_W-1:0]         cp_rdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    input  logic                      mem_abort,
    output logic [2:0]                cp_phase,
    output logic [$clog2(NUM_CP)-1:0] cp_num,
    output logic [DATA_W-1:0]         cp_wdata,
    output logic [DATA_W-1:0]         mem_addr,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [DATA_W-1:0]         mem_wdata,
    output logic                      done,
    output logic                      undef_trap,
    output logic                      cp_abort,
    output logic                      abandoned,
    output logic                      wb_req,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int CP_W = $clog2(NUM_CP);

    state_t            st;
    op_t               op_q;
    logic [CP_W-1:0]   cp_q;
    logic              wb_q, undef_q, abort_q, aband_q, wbr_q;
    logic [DATA_W-1:0] src_q, res_q;
    logic              deny, addr_fault, is_ldst, accept, step;
    resp_t             rsp;

    cp_entry_check #(
        .NUM_CP(NUM_CP), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_LIMIT(VEC_LIMIT)
    ) u_entry (
        .op(op), .cp_sel(cp_sel), .cp_perm(cp_perm), .addr(start_addr),
        .deny(deny), .addr_fault(addr_fault)
    );

    cp_addr_step #(.DATA_W(DATA_W), .STEP(4)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(start_addr),
        .step(step), .addr(mem_addr)
    );

    // Decode the response and the shared control terms.
    always_comb begin
        rsp     = resp_t'(cp_resp);
        is_ldst = (op_q == OP_LOAD) || (op_q == OP_STORE);
        accept  = (st == ST_IDLE) && start;
        step    = (st == ST_DATA) && (rsp == RSP_INC) && !mem_abort;
    end

    // Main sequencing state machine with captured instruction fields and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; op_q <= OP_TO_CP; cp_q <= '0; wb_q <= 1'b0;
            src_q <= '0; res_q <= '0;
            undef_q <= 1'b0; abort_q <= 1'b0; aband_q <= 1'b0; wbr_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    op_q <= op_t'(op); cp_q <= cp_sel; wb_q <= wb_bit;
                    src_q <= src_data; res_q <= '0;
                    undef_q <= 1'b0; abort_q <= 1'b0; aband_q <= 1'b0; wbr_q <= 1'b0;
                    if (deny) begin
                        undef_q <= 1'b1; st <= ST_END;
                    end else if (addr_fault) begin
                        abort_q <= 1'b1; st <= ST_END;
                    end else begin
                        st <= ST_FIRST;
                    end
                end
                ST_FIRST, ST_POLL: begin
                    case (rsp)
                        RSP_BUSY: st <= ST_WAIT;
                        RSP_CANT: begin
                            if (is_ldst) abort_q <= 1'b1;
                            else         undef_q <= 1'b1;
                            if (op_q == OP_FROM_CP) res_q <= DATA_W'(FLAG_PAT);
                            st <= ST_END;
                        end
                        default: begin
                            case (op_q)
                                OP_TO_CP:   st <= ST_CCYC;
                                OP_FROM_CP: begin res_q <= cp_rdata; st <= ST_CCYC; end
                                OP_LOAD:    begin wbr_q <= wb_q; st <= ST_XFER; end
                                OP_STORE:   begin wbr_q <= wb_q; st <= ST_DATA; end
                                default:    st <= ST_END;
                            endcase
                        end
                    endcase
                end
                ST_WAIT: st <= irq_pend ? ST_INTR : ST_POLL;
                ST_INTR: begin aband_q <= 1'b1; st <= ST_END; end
                ST_CCYC: st <= (op_q == OP_FROM_CP) ? ST_ICYC : ST_END;
                ST_ICYC: st <= ST_END;
                ST_XFER: st <= ST_DATA;
                ST_DATA: begin
                    if (mem_abort) begin
                        abort_q <= 1'b1; st <= ST_END;
                    end else if (rsp != RSP_INC) begin
                        st <= ST_END;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the handshake, memory and completion outputs from the state.
    always_comb begin
        case (st)
            ST_FIRST: cp_phase = PH_FIRST;
            ST_POLL:  cp_phase = PH_BUSY;
            ST_INTR:  cp_phase = PH_INTR;
            ST_XFER:  cp_phase = PH_XFER;
            ST_DATA:  cp_phase = PH_DATA;
            default:  cp_phase = PH_NONE;
        endcase
        cp_num     = cp_q;
        mem_rd     = (st == ST_DATA) && (op_q == OP_LOAD);
        mem_wr     = (st == ST_DATA) && (op_q == OP_STORE);
        cp_wdata   = mem_rd ? mem_rdata : src_q;
        mem_wdata  = cp_rdata;
        done       = (st == ST_END);
        undef_trap = done & undef_q;
        cp_abort   = done & abort_q;
        abandoned  = done & aband_q;
        wb_req     = done & wbr_q;
        rd_data    = res_q;
    end
endmodule

// File: rtl/cp_hs_checker.sv
`timescale 1ns/1ps
// Protocol checker for cp_hs_seq, attached by bind. Observes ports and the
// sequencer state; drives nothing.
module cp_hs_checker #(
    parameter int NUM_CP = 16,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start,
    input logic [$clog2(NUM_CP)-1:0] cp_sel,
    input logic [NUM_CP-1:0]         cp_perm,
    input logic [1:0]                cp_resp,
    input logic                      mem_abort,
    input logic [2:0]                cp_phase,
    input logic [DATA_W-1:0]         mem_addr,
    input logic                      done,
    input logic                      undef_trap,
    input logic                      cp_abort,
    input logic                      abandoned,
    input logic [3:0]                st_q
);
    // R1: completion is a single-cycle pulse
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: refused permission traps at once, with no phase
    assert_perm_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == 4'd0 && start && !cp_perm[cp_sel]) |=> (done && undef_trap && cp_phase == 3'd0));

    // R3: a busy answer is followed by an idle cycle
    assert_busy_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((cp_phase == 3'd1 || cp_phase == 3'd2) && cp_resp == 2'd0) |=> (cp_phase == 3'd0 && !done));

    // R4: an interrupt phase ends the instruction as abandoned
    assert_intr_abandon_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == 3'd3) |=> (done && abandoned));

    // R6 and R7: an INC answer in DATA advances the address by one word
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == 3'd5 && cp_resp == 2'd2 && !mem_abort) |=>
            (cp_phase == 3'd5 && mem_addr == $past(mem_addr) + DATA_W'(4)));

    // R12: a memory abort ends the transfer after the current word
    assert_mem_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_phase == 3'd5 && mem_abort) |=> (done && cp_abort));
endmodule

bind cp_hs_seq cp_hs_checker #(.NUM_CP(NUM_CP), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cp_sel(cp_sel), .cp_perm(cp_perm),
    .cp_resp(cp_resp), .mem_abort(mem_abort), .cp_phase(cp_phase),
    .mem_addr(mem_addr), .done(done), .undef_trap(undef_trap),
    .cp_abort(cp_abort), .abandoned(abandoned), .st_q(st)
);

// File: tb/cp_hs_seq_test.sv
`timescale 1ns/1ps
module cp_hs_seq_test;
    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  cp;
        logic [3:0]  busy;
        logic [1:0]  fin;
        logic [3:0]  incs;
        logic        irq;
        logic [3:0]  abw;
        logic        wb;
        logic [31:0] addr;
        logic [7:0]  lat;
        logic        undef;
        logic        abrt;
        logic        aband;
        logic [3:0]  words;
        logic        wbr;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 4'd1, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd3, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd1, 4'd2, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd4, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd2, 4'd3, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd2, 4'd3, 4'd2, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd6, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd1, 4'd2, 4'd1, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd6, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd0, 4'd1, 4'd1, 2'd3, 4'd0, 1'b1, 4'd15, 1'b0, 32'h0,         8'd4, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0},
        '{3'd0, 4'd12,4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd2, 4'd3, 4'd0, 2'd1, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd2, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd1, 4'd2, 4'd0, 2'd1, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0,         8'd2, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},
        '{3'd3, 4'd4, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b1, 32'h100,       8'd4, 1'b0, 1'b0, 1'b0, 4'd1, 1'b1},
        '{3'd3, 4'd4, 4'd0, 2'd3, 4'd3, 1'b0, 4'd15, 1'b0, 32'h100,       8'd7, 1'b0, 1'b0, 1'b0, 4'd4, 1'b0},
        '{3'd4, 4'd5, 4'd0, 2'd3, 4'd2, 1'b0, 4'd15, 1'b0, 32'h120,       8'd5, 1'b0, 1'b0, 1'b0, 4'd3, 1'b0},
        '{3'd3, 4'd4, 4'd0, 2'd1, 4'd0, 1'b0, 4'd15, 1'b1, 32'h100,       8'd2, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{3'd4, 4'd5, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b1, 32'h10,        8'd1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{3'd3, 4'd4, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h0400_0000, 8'd1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{3'd3, 4'd4, 4'd0, 2'd3, 4'd4, 1'b0, 4'd1,  1'b1, 32'h100,       8'd5, 1'b0, 1'b1, 1'b0, 4'd2, 1'b1},
        '{3'd3, 4'd4, 4'd1, 2'd1, 4'd0, 1'b0, 4'd15, 1'b0, 32'h100,       8'd4, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},
        '{3'd3, 4'd4, 4'd0, 2'd3, 4'd0, 1'b0, 4'd15, 1'b0, 32'h10,        8'd4, 1'b0, 1'b0, 1'b0, 4'd1, 1'b0},
        '{3'd4, 4'd5, 4'd1, 2'd3, 4'd0, 1'b1, 4'd15, 1'b0, 32'h140,       8'd4, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0},
        '{3'd2, 4'd3, 4'd0, 2'd3, 4'd0, 1'b1, 4'd15, 1'b0, 32'h0,         8'd2, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0}
    };

    string tags [NV] = '{"R11", "R11", "R11", "R3", "R3", "R4", "R2", "R5", "R5", "R6",
                         "R6", "R7", "R5", "R8", "R8", "R12", "R5", "R8", "R4", "R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tb_clr = 1'b0;
    vec_t        cur = '0;
    logic [1:0]  cp_resp;
    logic [31:0] cp_rdata, mem_rdata;
    logic        mem_abort;
    logic [2:0]  cp_phase;
    logic [3:0]  cp_num;
    logic [31:0] cp_wdata, mem_addr, mem_wdata, rd_data;
    logic        mem_rd, mem_wr, done, undef_trap, cp_abort, abandoned, wb_req;
    logic [31:0] mem [16];
    int          polls, words, nph, nint;
    logic [2:0]  first_ph;
    logic [31:0] first_wd, last_wd, last_ad;
    int          checks = 0, fails = 0;

    always #10 clk = ~clk;

    cp_hs_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(cur.op), .cp_sel(cur.cp),
        .wb_bit(cur.wb), .start_addr(cur.addr), .src_data(32'h5A5A_0001),
        .cp_perm(16'hEFFF), .irq_pend(cur.irq), .cp_resp(cp_resp),
        .cp_rdata(cp_rdata), .mem_rdata(mem_rdata), .mem_abort(mem_abort),
        .cp_phase(cp_phase), .cp_num(cp_num), .cp_wdata(cp_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .done(done), .undef_trap(undef_trap),
        .cp_abort(cp_abort), .abandoned(abandoned), .wb_req(wb_req),
        .rd_data(rd_data)
    );

    // Coprocessor and memory models
    always_comb begin
        cp_resp = 2'd3;
        if (cp_phase == 3'd1 || cp_phase == 3'd2)
            cp_resp = (polls < int'(cur.busy)) ? 2'd0 : cur.fin;
        else if (cp_phase == 3'd5)
            cp_resp = (words < int'(cur.incs)) ? 2'd2 : 2'd3;
        cp_rdata  = 32'hC0DE_0000 + 32'(words);
        mem_rdata = mem[mem_addr[5:2]];
        mem_abort = (cp_phase == 3'd5) && (words == int'(cur.abw));
    end

    always @(posedge clk) begin
        if (tb_clr) begin
            polls <= 0; words <= 0; nph <= 0; nint <= 0; first_ph <= 3'd0;
        end else begin
            if (cp_phase == 3'd1 || cp_phase == 3'd2) polls <= polls + 1;
            if (cp_phase != 3'd0) begin
                nph <= nph + 1;
                if (nph == 0) first_ph <= cp_phase;
            end
            if (cp_phase == 3'd3) nint <= nint + 1;
            if (cp_phase == 3'd5) begin
                words <= words + 1;
                if (words == 0) first_wd <= cp_wdata;
                last_wd <= cp_wdata;
                last_ad <= mem_addr;
            end
            if (mem_wr) mem[mem_addr[5:2]] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, output int lat);
        @(negedge clk);
        cur = v; tb_clr = 1'b1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; tb_clr = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int lat;
        vec_t d;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + 32'(i);
        tb_clr = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(cp_phase == 3'd0 && !done && !mem_rd && !mem_wr && !wb_req, "R1", "reset outputs",
            {cp_phase, done, mem_rd, mem_wr, wb_req}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], lat);
            chk(lat == int'(VECS[i].lat), tags[i], $sformatf("latency vec%0d", i), lat, VECS[i].lat);
            chk({undef_trap, cp_abort, abandoned} == {VECS[i].undef, VECS[i].abrt, VECS[i].aband},
                tags[i], $sformatf("flags vec%0d", i), {undef_trap, cp_abort, abandoned},
                {VECS[i].undef, VECS[i].abrt, VECS[i].aband});
            chk(words == int'(VECS[i].words), tags[i], $sformatf("data words vec%0d", i), words, VECS[i].words);
            chk(wb_req == VECS[i].wbr, "R9", $sformatf("writeback vec%0d", i), wb_req, VECS[i].wbr);
            if (VECS[i].lat == 8'd1)
                chk(nph == 0, tags[i], $sformatf("no phase vec%0d", i), nph, 0);
            else begin
                chk(first_ph == 3'd1, "R1", $sformatf("opening phase vec%0d", i), first_ph, 3'd1);
                chk(polls == int'(VECS[i].busy) + (VECS[i].aband ? 0 : 1), "R3",
                    $sformatf("poll count vec%0d", i), polls, VECS[i].busy);
                chk(nint == int'(VECS[i].aband), "R4", $sformatf("interrupt phases vec%0d", i), nint, VECS[i].aband);
            end
            @(negedge clk);
            chk(!done, "R1", $sformatf("done pulse width vec%0d", i), done, 0);
        end

        // R7: store wrote three coprocessor words from 0x120 upward
        for (int k = 0; k < 3; k++)
            chk(mem[8 + k] == 32'hC0DE_0000 + 32'(k), "R7", $sformatf("stored word %0d", k),
                mem[8 + k], 32'hC0DE_0000 + 32'(k));

        // R10: accepted read returns coprocessor word
        d = VECS[1];
        run_vec(d, lat);
        chk(rd_data == 32'hC0DE_0000, "R10", "read data", rd_data, 32'hC0DE_0000);
        // R10: refused read returns flag pattern
        d = VECS[8];
        run_vec(d, lat);
        chk(rd_data == 32'hF000_0000, "R10", "refused read data", rd_data, 32'hF000_0000);

        // R6: two-word load passes memory words at 0x100 and 0x104
        d = VECS[9];
        d.incs = 4'd1; d.lat = 8'd5; d.wb = 1'b0;
        run_vec(d, lat);
        chk(lat == 5, "R6", "two-word load latency", lat, 5);
        chk(first_wd == 32'hA000_0000, "R6", "first load word", first_wd, 32'hA000_0000);
        chk(last_wd == 32'hA000_0001, "R6", "second load word", last_wd, 32'hA000_0001);
        chk(last_ad == 32'h104, "R6", "second load address", last_ad, 32'h104);
        chk(!wb_req, "R9", "no writeback without bit", wb_req, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule